// File: doc/BRIEF.md
# Serial-In Parallel-Out Register with Separate Output Latch

This block turns a serial bit stream into a parallel word. Bits enter a chain of flip-flops one stage per rising edge of the shift clock. The chain's contents become visible only when a rising edge of a separate storage clock copies the whole chain into an output register. The parallel outputs therefore stay steady while a new word is shifted in behind them. The last chain stage is also brought out as a serial cascade bit. Feeding that bit into the serial input of a second instance builds a longer chain.

Each bank has its own clock and its own active-low asynchronous clear. The output word can be blanked without disturbing the chain, and the chain can be flushed without disturbing the output word. When both clocks are driven by the same signal, the storage bank captures the chain as it stood before the shared edge. The outputs then lag the chain by one shift.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising edge of `shift_clk_i`, stage 0 of the chain takes `ser_i` and stage k takes the old value of stage k-1. Shifting an 8-bit word in most-significant bit first therefore leaves bit k of the word in stage k.
- R2: `par_o` is driven only by the storage register. On each rising edge of `store_clk_i`, the storage register loads all chain stages at once, with bit k of `par_o` taken from stage k.
- R3: Shift clock edges without a storage clock edge leave `par_o` unchanged.
- R4: When both clocks rise together, `par_o` takes the chain contents from before that edge, while the chain itself advances as in R1.
- R5: `cascade_o` always equals the last chain stage. With two instances chained through it, 16 bits shifted in most-significant bit first leave the upper byte in the downstream instance and the lower byte in the upstream one.
- R6: Driving `store_rst_ni` low zeroes `par_o` at once, with no clock edge needed, and leaves the chain untouched.
- R7: Driving `shift_rst_ni` low zeroes every chain stage and `cascade_o` at once and leaves `par_o` unchanged. A later storage clock edge then loads all zeros.
- R8: After a clear is released, the first rising edge of that bank's own clock already performs a normal shift or load.
- R9: The chain length and output width are set by the parameter `WIDTH`, which defaults to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift chain clock, rising edge active |
| shift_rst_ni | input | 1 | Asynchronous active-low clear of the shift chain |
| store_clk_i | input | 1 | Storage register clock, rising edge active |
| store_rst_ni | input | 1 | Asynchronous active-low clear of the storage register |
| ser_i | input | 1 | Serial data into stage 0 |
| par_o | output | WIDTH | Parallel word from the storage register |
| cascade_o | output | 1 | Last chain stage, for feeding the next instance |

## Verification
The properties assume that a clear is asserted and released only while the matching clock input is low. They also assume that `ser_i` changes only away from rising shift clock edges. The bench derives both clocks by gating one free-running clock with enables that change only on its falling edge. It drives data and clears on that same falling edge, so every edge sees settled inputs. A clear that falls entirely between two clock edges is covered by a per-bank flag that keeps the next edge's comparison out of the checks.

// File: rtl/shift_store_pkg.sv
package shift_store_pkg;
  parameter int unsigned SSR_DEF_WIDTH = 8;
endpackage

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned WIDTH = shift_store_pkg::SSR_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stages_o,
  output logic             tap_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  assign stage_d = {stage_q[LAST-1:0], ser_i};

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= stage_d[g];
    end
  end

  assign stages_o = stage_q;
  assign tap_o    = stage_q[LAST];

  // set on the first edge after any clear; gates comparisons across a clear
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  p_chain_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> stage_q[LAST:1] == $past(stage_q[LAST-1:0]));

  p_chain_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> stage_q[0] == $past(ser_i));
endmodule

// File: rtl/store_bank.sv
module store_bank #(
  parameter int unsigned WIDTH = shift_store_pkg::SSR_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= d_i;
  end

  assign q_o = hold_q;

  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  p_store_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> q_o == $past(d_i));
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
  parameter int unsigned WIDTH = shift_store_pkg::SSR_DEF_WIDTH
) (
  input  logic             shift_clk_i,
  input  logic             shift_rst_ni,
  input  logic             store_clk_i,
  input  logic             store_rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] par_o,
  output logic             cascade_o
);
  logic [WIDTH-1:0] chain_w;

  shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i    (shift_clk_i),
    .rst_ni   (shift_rst_ni),
    .ser_i    (ser_i),
    .stages_o (chain_w),
    .tap_o    (cascade_o)
  );

  store_bank #(.WIDTH(WIDTH)) u_store (
    .clk_i  (store_clk_i),
    .rst_ni (store_rst_ni),
    .d_i    (chain_w),
    .q_o    (par_o)
  );

  // a store edge seen while the chain is held clear leaves zeros behind
  p_shift_clear_flush_r7: assert property (@(posedge store_clk_i) disable iff (!store_rst_ni)
    !shift_rst_ni |=> par_o == '0);
endmodule

// File: tb/shift_store_reg_test.sv
module shift_store_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic sh_en = 1'b0, st_en = 1'b0;
  logic sh_rn = 1'b1, st_rn = 1'b1;
  logic ser = 1'b0;
  logic shift_clk, store_clk;
  logic [W-1:0] par_a, par_b;
  logic cas_a, cas_b;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign shift_clk = clk & sh_en;
  assign store_clk = clk & st_en;

  shift_store_reg #(.WIDTH(W)) uut (
    .shift_clk_i(shift_clk), .shift_rst_ni(sh_rn), .store_clk_i(store_clk),
    .store_rst_ni(st_rn), .ser_i(ser), .par_o(par_a), .cascade_o(cas_a));

  shift_store_reg #(.WIDTH(W)) uut_b (
    .shift_clk_i(shift_clk), .shift_rst_ni(sh_rn), .store_clk_i(store_clk),
    .store_rst_ni(st_rn), .ser_i(cas_a), .par_o(par_b), .cascade_o(cas_b));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser = b; sh_en = 1'b1;
    @(negedge clk); sh_en = 1'b0;
  endtask

  task automatic store_pulse();
    @(negedge clk); st_en = 1'b1;
    @(negedge clk); st_en = 1'b0;
  endtask

  task automatic tied_pulse(input logic b);
    @(negedge clk); ser = b; sh_en = 1'b1; st_en = 1'b1;
    @(negedge clk); sh_en = 1'b0; st_en = 1'b0;
  endtask

  task automatic t_reset();
    #1; sh_rn = 1'b0; st_rn = 1'b0;
    repeat (2) @(negedge clk);
    sh_rn = 1'b1; st_rn = 1'b1;
    @(negedge clk);
    check("R6 reset par", {8'h0, par_a}, 16'h0);
    check("R7 reset cascade", {15'h0, cas_a}, 16'h0);
    check("R6 reset par b", {8'h0, par_b}, 16'h0);
  endtask

  task automatic t_shift_hold();
    logic [7:0] v = 8'hA5;
    logic held = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      shift_bit(v[i]);
      if (par_a !== 8'h00) held = 1'b0;
    end
    check("R3 par held while shifting", {15'h0, held}, 16'h1);
    check("R5 cascade is last stage", {15'h0, cas_a}, 16'h1);
    store_pulse();
    check("R1 R2 stored word", {8'h0, par_a}, 16'h00A5);
  endtask

  task automatic t_tied();
    tied_pulse(1'b0);
    check("R4 tied clocks old contents", {8'h0, par_a}, 16'h00A5);
    store_pulse();
    check("R4 chain advanced", {8'h0, par_a}, 16'h004A);
  endtask

  task automatic t_store_clear();
    @(negedge clk); st_rn = 1'b0;
    #1;
    check("R6 async output clear", {8'h0, par_a}, 16'h0);
    @(negedge clk); st_rn = 1'b1;
    store_pulse();
    check("R6 R8 chain untouched, load after release", {8'h0, par_a}, 16'h004A);
  endtask

  task automatic t_shift_clear();
    shift_bit(1'b1);
    check("R5 cascade after shift", {15'h0, cas_a}, 16'h1);
    @(negedge clk); sh_rn = 1'b0;
    #1;
    check("R7 cascade cleared", {15'h0, cas_a}, 16'h0);
    check("R7 par unchanged by chain clear", {8'h0, par_a}, 16'h004A);
    @(negedge clk); sh_rn = 1'b1;
    store_pulse();
    check("R7 zeros loaded", {8'h0, par_a}, 16'h0);
  endtask

  task automatic t_release();
    @(negedge clk); sh_rn = 1'b0;
    @(negedge clk); sh_rn = 1'b1;
    shift_bit(1'b1);
    check("R8 cascade after one shift", {15'h0, cas_a}, 16'h0);
    store_pulse();
    check("R8 first edge after release shifts", {8'h0, par_a}, 16'h0001);
  endtask

  task automatic t_cascade();
    logic [15:0] v = 16'hC35A;
    for (int i = 15; i >= 0; i--) shift_bit(v[i]);
    store_pulse();
    check("R5 downstream byte", {8'h0, par_b}, 16'h00C3);
    check("R5 upstream byte", {8'h0, par_a}, 16'h005A);
    check("R5 R9 downstream cascade", {15'h0, cas_b}, 16'h1);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_shift_hold();
    t_tied();
    t_store_clear();
    t_shift_clear();
    t_release();
    t_cascade();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule